// File: doc/BRIEF.md
# Soft-Start Ramp Counter

This block holds the on-time limit that a resonant converter controller uses while its output ramps up after a start. When the startup sequencer finishes, it strobes in the last upper-switch on-time it reached. From then on, every K-th lower-switch conduction pulse raises the count by a configurable step. This continues until the count reaches the configured maximum on-time, which ends the soft-start phase.

The count is the reference for the maximum on-time comparator. Its upper bits are the code for a ramp DAC that pulls the internal feedback level down and then releases it. If the feedback input falls below the skip threshold, the counter jumps straight to the maximum and soft-start ends at once. The analog DAC lies outside the block.

Top module: `ss_ramp_counter`

## Requirements
- R1: After reset, `count` and `dacCode` are 0 and `ssActive` is 0.
- R2: A `loadStb` with `loadVal` below `maxCfg` makes `count` equal `loadVal` and raises `ssActive`, both visible one clock later.
- R3: A `loadStb` with `loadVal` at or above `maxCfg` makes `count` equal `maxCfg` one clock later, and `ssActive` stays 0.
- R4: While `ssActive` is 1, each qualifying `lowPulse` (a single-cycle high) adds `stepCfg` to `count`, visible one clock later.
- R5: Lower pulses pass through a divide-by-K prescaler with K = `divCfg`, where values 0 and 1 both mean every pulse. Only every K-th pulse counts as qualifying.
- R6: A step that would reach or pass `maxCfg` sets `count` to `maxCfg` and clears `ssActive` in the same clock.
- R7: `fbSkip` high makes `count` equal `maxCfg` and `ssActive` 0 one clock later. It has priority over `loadStb` and `lowPulse`.
- R8: A load restarts the prescaler, so the K-th pulse after the load is the first qualifying one.
- R9: While `ssActive` is 0, `lowPulse` leaves `count` unchanged.
- R10: `dacCode` always equals the upper DAC_W bits of `count`, which is `count >> (CNT_W-DAC_W)`.
- R11: Without a load or skip, and with `count` at most `maxCfg`, `count` never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| loadStb | input | 1 | End-of-startup load strobe |
| loadVal | input | CNT_W | Final startup upper on-time |
| lowPulse | input | 1 | One-cycle event per lower-switch on-time |
| fbSkip | input | 1 | Feedback below skip threshold |
| stepCfg | input | STEP_W | Increment per qualifying pulse |
| divCfg | input | DIV_W | Prescaler divide ratio K |
| maxCfg | input | CNT_W | Maximum on-time |
| count | output | CNT_W | Soft-start count / comparator reference |
| dacCode | output | DAC_W | Ramp DAC code |
| ssActive | output | 1 | Soft-start in progress |

## Verification
The bench builds the block with CNT_W=10, STEP_W=5, DIV_W=3 and DAC_W=6. These sizes keep the ramps to a few pulses. Setting K to 3 exercises the prescaler count-out and the restart on load. A maximum of 200 lets a step of 20 overshoot, which tests saturation. A load value of 300 sits above the maximum but still fits in the count. With a 4-bit DAC shift, values such as 100 and 200 give distinct codes.

// File: rtl/ss_ramp_pkg.sv
package ss_ramp_pkg;
  typedef struct packed {
    logic jumpMax;
    logic load;
    logic step;
  } ss_strobe_t;
endpackage

// File: rtl/ss_ramp_ctrl.sv
module ss_ramp_ctrl
  import ss_ramp_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadStb,
  input  logic             lowPulse,
  input  logic             fbSkip,
  input  logic [DIV_W-1:0] divCfg,
  input  logic             stepSat,
  input  logic             loadSat,
  output ss_strobe_t       strobes,
  output logic             ssActive
);
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] kEff;
  logic             divFire;

  // Divide ratios 0 and 1 both pass every pulse.
  assign kEff    = (divCfg == '0) ? DIV_W'(1) : divCfg;
  assign divFire = (divCnt >= (kEff - DIV_W'(1)));

  always_comb begin
    strobes.jumpMax = fbSkip;
    strobes.load    = loadStb && !fbSkip;
    strobes.step    = ssActive && lowPulse && divFire && !loadStb && !fbSkip;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt   <= '0;
      ssActive <= 1'b0;
    end else if (strobes.jumpMax) begin
      divCnt   <= '0;
      ssActive <= 1'b0;
    end else if (strobes.load) begin
      divCnt   <= '0;
      ssActive <= !loadSat;
    end else if (ssActive && lowPulse) begin
      if (divFire) begin
        divCnt <= '0;
        if (stepSat) ssActive <= 1'b0;
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end

  // R7: a skip always ends soft-start
  p_skip_ends_r7: assert property (@(posedge clk) disable iff (!rstN)
    fbSkip |=> !ssActive);
  // R9: with no load, an idle block stays idle
  p_idle_stays_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!ssActive && !loadStb) |=> !ssActive);
  // R4: steps are only issued during soft-start
  p_step_active_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |-> ssActive);
  // R8: a load restarts the prescaler
  p_div_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb || fbSkip) |=> (divCnt == '0));
endmodule

// File: rtl/ss_ramp_dp.sv
module ss_ramp_dp
  import ss_ramp_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int STEP_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ss_strobe_t        strobes,
  input  logic [CNT_W-1:0]  loadVal,
  input  logic [STEP_W-1:0] stepCfg,
  input  logic [CNT_W-1:0]  maxCfg,
  output logic [CNT_W-1:0]  count,
  output logic              stepSat,
  output logic              loadSat
);
  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] stepSum;

  assign stepSum = {1'b0, count} + SUM_W'(stepCfg);
  assign stepSat = (stepSum >= {1'b0, maxCfg});
  assign loadSat = (loadVal >= maxCfg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobes.jumpMax) begin
      count <= maxCfg;
    end else if (strobes.load) begin
      count <= loadSat ? maxCfg : loadVal;
    end else if (strobes.step) begin
      count <= stepSat ? maxCfg : stepSum[CNT_W-1:0];
    end
  end

  // R7: a skip forces the maximum
  p_skip_max_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.jumpMax |=> (count == $past(maxCfg)));
  // R11: the count is monotonic between loads
  p_monotonic_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.jumpMax && count <= maxCfg) |=> (count >= $past(count)));
  // R6: a step never carries past the maximum
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && count <= maxCfg) |=> (count <= $past(maxCfg)));
endmodule

// File: rtl/ss_ramp_counter.sv
module ss_ramp_counter
  import ss_ramp_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int STEP_W = 6,
  parameter int DIV_W  = 4,
  parameter int DAC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic [CNT_W-1:0]  loadVal,
  input  logic              lowPulse,
  input  logic              fbSkip,
  input  logic [STEP_W-1:0] stepCfg,
  input  logic [DIV_W-1:0]  divCfg,
  input  logic [CNT_W-1:0]  maxCfg,
  output logic [CNT_W-1:0]  count,
  output logic [DAC_W-1:0]  dacCode,
  output logic              ssActive
);
  localparam int DAC_SHIFT = CNT_W - DAC_W;

  ss_strobe_t strobes;
  logic       stepSat;
  logic       loadSat;

  ss_ramp_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .lowPulse(lowPulse),
    .fbSkip(fbSkip), .divCfg(divCfg), .stepSat(stepSat), .loadSat(loadSat),
    .strobes(strobes), .ssActive(ssActive)
  );

  ss_ramp_dp #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadVal(loadVal),
    .stepCfg(stepCfg), .maxCfg(maxCfg), .count(count),
    .stepSat(stepSat), .loadSat(loadSat)
  );

  // R10: the DAC code follows the upper bits of the count
  assign dacCode = count[CNT_W-1:DAC_SHIFT];

  // R10: the DAC code never lags the count
  p_dac_track_r10: assert property (@(posedge clk) disable iff (!rstN)
    (32'(dacCode) == (32'(count) >> DAC_SHIFT)));
endmodule

// File: tb/ss_ramp_counter_test.sv
module ss_ramp_counter_test;
  localparam int CNT_W = 10, STEP_W = 5, DIV_W = 3, DAC_W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadStb = 1'b0, lowPulse = 1'b0, fbSkip = 1'b0;
  logic [CNT_W-1:0] loadVal = '0, maxCfg = 10'd200;
  logic [STEP_W-1:0] stepCfg = 5'd5;
  logic [DIV_W-1:0] divCfg = 3'd1;
  logic [CNT_W-1:0] count;
  logic [DAC_W-1:0] dacCode;
  logic ssActive;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  ss_ramp_counter #(.CNT_W(CNT_W), .STEP_W(STEP_W), .DIV_W(DIV_W), .DAC_W(DAC_W)) uut (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .loadVal(loadVal),
    .lowPulse(lowPulse), .fbSkip(fbSkip), .stepCfg(stepCfg), .divCfg(divCfg),
    .maxCfg(maxCfg), .count(count), .dacCode(dacCode), .ssActive(ssActive)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doLoad(int v);
    @(negedge clk) loadVal = CNT_W'(v); loadStb = 1'b1;
    @(negedge clk) loadStb = 1'b0;
  endtask

  task automatic doPulse();
    @(negedge clk) lowPulse = 1'b1;
    @(negedge clk) lowPulse = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 count", int'(count), 0);
    chk("R1 dac", int'(dacCode), 0);
    chk("R1 active", int'(ssActive), 0);
  endtask

  task automatic testIdle();
    doPulse(); doPulse();
    chk("R9 idle pulses", int'(count), 0);
    chk("R9 idle active", int'(ssActive), 0);
  endtask

  task automatic testLoad();
    maxCfg = 10'd200;
    doLoad(100);
    chk("R2 count", int'(count), 100);
    chk("R2 active", int'(ssActive), 1);
    chk("R10 dac", int'(dacCode), 6);
  endtask

  task automatic testStep();
    divCfg = 3'd1; stepCfg = 5'd5;
    doLoad(100);
    doPulse();
    chk("R4 one step", int'(count), 105);
    doPulse();
    chk("R4 two steps", int'(count), 110);
  endtask

  task automatic testDivider();
    divCfg = 3'd3; stepCfg = 5'd5;
    doLoad(100);
    doPulse(); doPulse();
    chk("R5 before Kth", int'(count), 100);
    doPulse();
    chk("R5 Kth pulse", int'(count), 105);
  endtask

  task automatic testRestart();
    divCfg = 3'd3;
    doLoad(100);
    doPulse(); doPulse();
    doLoad(100);
    doPulse(); doPulse();
    chk("R8 restarted", int'(count), 100);
    doPulse();
    chk("R8 third after load", int'(count), 105);
  endtask

  task automatic testSaturate();
    divCfg = 3'd0; stepCfg = 5'd20;
    doLoad(195);
    doPulse();
    chk("R6 clamp", int'(count), 200);
    chk("R6 active off", int'(ssActive), 0);
    chk("R10 dac max", int'(dacCode), 12);
    doPulse();
    chk("R9 after end", int'(count), 200);
  endtask

  task automatic testSkip();
    stepCfg = 5'd5; divCfg = 3'd1;
    doLoad(50);
    chk("R2 pre-skip", int'(ssActive), 1);
    @(negedge clk) fbSkip = 1'b1; loadStb = 1'b1; loadVal = 10'd60; lowPulse = 1'b1;
    @(negedge clk) fbSkip = 1'b0; loadStb = 1'b0; lowPulse = 1'b0;
    chk("R7 jump", int'(count), 200);
    chk("R7 active off", int'(ssActive), 0);
  endtask

  task automatic testOverMax();
    doLoad(300);
    chk("R3 clamp load", int'(count), 200);
    chk("R3 not active", int'(ssActive), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIdle();
    testLoad();
    testStep();
    testDivider();
    testRestart();
    testSaturate();
    testSkip();
    testOverMax();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule